// File: doc/BRIEF.md
# Block Fetch DMA for a Transform Accelerator

This block is a bus master that copies square pixel tiles from system memory into the input RAM of a transform engine. Software programs a source address, a line stride and a number of tiles through a small register port, then sets a go bit. For each tile the block reads eight lines of eight bytes, two 32-bit words per line. Each word goes into the engine's input RAM at a fixed slot. When the tile is complete the block pulses a start strobe and watches the engine's busy flag.

The block gives up the bus between tiles. It fetches the next tile while the engine is still working on the previous one, but it issues the next start only once busy has dropped. After the last tile it waits for the engine to finish and then returns to idle. At that point the running flag in the status word clears. Successive tiles sit side by side in memory, eight bytes apart.

Top module: `blkfetch_dma`

## Requirements
- R1: After reset, m_cyc, m_stb, xf_start and ram_we are low, and the status word (word index 3) reads 0.
- R2: Register words are selected by s_adr: 0 = source address, 1 = line stride, 2 = tile count (low CNT_W bits, upper bits read 0), 3 = control/status. Words 0 to 2 read back what was written. s_ack is high for exactly one cycle, in the cycle after a request is presented.
- R3: A write to word 3 with bit 0 set, made while idle with a nonzero tile count, starts a run. Bit 0 of word 3 then reads 1 while the run is active. With a tile count of 0, the same write leaves the block idle with no bus activity.
- R4: The m-th word fetched overall has address src + 8*k + r*stride + 4*w, where k is the tile, r the line (0..7) and w the word in the line (0..1). Words are fetched in order of k, then r, then w. m_adr holds steady while a read waits for m_ack.
- R5: The cycle after each accepted read (m_cyc, m_stb and m_ack high), ram_we is high for one cycle. ram_waddr is then 2*r + w and ram_wdata is the word that was returned.
- R6: m_cyc and m_stb stay high together for all 16 reads of a tile and go low in the cycle after the 16th m_ack.
- R7: xf_start pulses for exactly one cycle once per tile, after the tile's 16th word is written. It is never raised while xf_busy is high or before the previous transform has shown busy and finished.
- R8: Between two tiles of a run, m_cyc is low for at least one cycle.
- R9: The status bit clears only after xf_busy has fallen following the last tile's start. After that, no further bus reads occur.
- R10: A go write made while a run is active has no effect: the run performs exactly the programmed number of tiles and start pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_cyc | input | 1 | Register port cycle |
| s_stb | input | 1 | Register port strobe |
| s_we | input | 1 | Register port write enable |
| s_adr | input | 2 | Register word index |
| s_dat_i | input | 32 | Register write data |
| s_dat_o | output | 32 | Register read data |
| s_ack | output | 1 | Register port acknowledge |
| m_cyc | output | 1 | Master bus cycle |
| m_stb | output | 1 | Master strobe |
| m_adr | output | 32 | Master byte address |
| m_dat_i | input | 32 | Master read data |
| m_ack | input | 1 | Master acknowledge |
| ram_wdata | output | 32 | Input RAM write data |
| ram_waddr | output | 4 | Input RAM word address |
| ram_we | output | 1 | Input RAM write enable |
| xf_start | output | 1 | One-cycle transform start strobe |
| xf_busy | input | 1 | Transform in progress |

## Verification
Four properties are checked on every cycle: the start strobe lasts one cycle and follows a cycle with busy low, each RAM write follows an accepted read, the address holds while a read waits, and the register acknowledge lasts one cycle. The remaining behaviour only shows up in the bench's scenarios against a queue-based model. That covers the exact address sequence across tiles and strides, the RAM slot and data of every word, and the bus release after each tile. It also covers the count of start pulses, go requests that are ignored during a run or when the count is zero, and the ordering of status clear against busy. The bench uses both short and long busy windows, so the next fetch sometimes finishes before the engine and sometimes after it.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_FETCH     = 3'd1,
    ST_HOLD      = 3'd2,
    ST_HOLD_LAST = 3'd3,
    ST_YIELD     = 3'd4
  } bf_state_e;
endpackage

// File: rtl/bf_csr.sv
module bf_csr #(
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_cyc,
  input  logic             s_stb,
  input  logic             s_we,
  input  logic [1:0]       s_adr,
  input  logic [DW-1:0]    s_dat_i,
  output logic [DW-1:0]    s_dat_o,
  output logic             s_ack,
  input  logic             running,
  output logic [DW-1:0]    cfg_src,
  output logic [DW-1:0]    cfg_stride,
  output logic [CNT_W-1:0] cfg_count,
  output logic             go
);
  logic          req;
  logic          wr;
  logic [DW-1:0] rd_mux;

  assign req = s_cyc && s_stb && !s_ack;
  assign wr  = req && s_we;

  always_comb begin
    case (s_adr)
      2'd0:    rd_mux = cfg_src;
      2'd1:    rd_mux = cfg_stride;
      2'd2:    rd_mux = DW'(cfg_count);
      default: rd_mux = DW'(running);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ack      <= 1'b0;
      s_dat_o    <= '0;
      cfg_src    <= '0;
      cfg_stride <= '0;
      cfg_count  <= '0;
      go         <= 1'b0;
    end else begin
      s_ack <= req;
      go    <= wr && (s_adr == 2'd3) && s_dat_i[0];
      if (req)                     s_dat_o    <= rd_mux;
      if (wr && s_adr == 2'd0)     cfg_src    <= s_dat_i;
      if (wr && s_adr == 2'd1)     cfg_stride <= s_dat_i;
      if (wr && s_adr == 2'd2)     cfg_count  <= s_dat_i[CNT_W-1:0];
    end
  end

  // R2: acknowledge lasts a single cycle
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack |=> !s_ack);
endmodule

// File: rtl/bf_addr.sv
module bf_addr #(
  parameter int AW    = 32,
  parameter int ROWS  = 8,
  parameter int WPR   = 2,
  localparam int WIDX_W    = $clog2(ROWS * WPR),
  localparam int WPR_LOG   = $clog2(WPR),
  localparam int ROW_BYTES = WPR * 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [AW-1:0]     src,
  input  logic [AW-1:0]     stride,
  output logic [AW-1:0]     adr,
  output logic [WIDX_W-1:0] widx,
  output logic              last_word
);
  logic [AW-1:0] blk_base;
  logic [AW-1:0] row_base;
  logic          row_end;

  assign last_word = &widx;
  assign row_end   = &widx[WPR_LOG-1:0];
  assign adr       = row_base + AW'({widx[WPR_LOG-1:0], 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_base <= '0;
      row_base <= '0;
      widx     <= '0;
    end else if (load) begin
      blk_base <= src;
      row_base <= src;
      widx     <= '0;
    end else if (step) begin
      widx <= widx + 1'b1;
      if (last_word) begin
        blk_base <= blk_base + AW'(ROW_BYTES);
        row_base <= blk_base + AW'(ROW_BYTES);
      end else if (row_end) begin
        row_base <= row_base + stride;
      end
    end
  end
endmodule

// File: rtl/bf_ctrl.sv
module bf_ctrl
  import bf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             m_ack,
  input  logic             last_word,
  input  logic             xf_busy,
  output logic             m_cyc,
  output logic             m_stb,
  output logic             load,
  output logic             step,
  output logic             xf_start,
  output logic             running
);
  bf_state_e        state_q, state_d;
  logic [CNT_W-1:0] left_q;
  logic             pend_q;
  logic             fire;

  assign load    = (state_q == ST_IDLE) && go && (cfg_count != '0);
  assign m_cyc   = (state_q == ST_FETCH);
  assign m_stb   = m_cyc;
  assign step    = m_cyc && m_ack;
  assign fire    = (state_q == ST_HOLD) && !xf_busy && !pend_q;
  assign running = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (load) state_d = ST_FETCH;
      ST_FETCH:     if (step && last_word) state_d = ST_HOLD;
      ST_HOLD:      if (fire) state_d = (left_q == CNT_W'(1)) ? ST_HOLD_LAST : ST_YIELD;
      ST_YIELD:     state_d = ST_FETCH;
      ST_HOLD_LAST: if (!xf_busy && !pend_q) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      left_q   <= '0;
      pend_q   <= 1'b0;
      xf_start <= 1'b0;
    end else begin
      state_q  <= state_d;
      xf_start <= fire;
      if (fire)         pend_q <= 1'b1;
      else if (xf_busy) pend_q <= 1'b0;
      if (load)         left_q <= cfg_count;
      else if (fire)    left_q <= left_q - 1'b1;
    end
  end

  // R7: start is a single-cycle pulse
  a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xf_start |=> !xf_start);
  // R7: start only follows a cycle in which the engine was idle
  a_r7_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    xf_start |-> !$past(xf_busy));
  // R9: running clears only after busy has been low
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> !$past(xf_busy));
endmodule

// File: rtl/blkfetch_dma.sv
module blkfetch_dma #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16,
  parameter int ROWS  = 8,
  parameter int WPR   = 2,
  localparam int RAM_AW = $clog2(ROWS * WPR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_cyc,
  input  logic              s_stb,
  input  logic              s_we,
  input  logic [1:0]        s_adr,
  input  logic [DW-1:0]     s_dat_i,
  output logic [DW-1:0]     s_dat_o,
  output logic              s_ack,
  output logic              m_cyc,
  output logic              m_stb,
  output logic [AW-1:0]     m_adr,
  input  logic [DW-1:0]     m_dat_i,
  input  logic              m_ack,
  output logic [DW-1:0]     ram_wdata,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic              ram_we,
  output logic              xf_start,
  input  logic              xf_busy
);
  logic [DW-1:0]     cfg_src, cfg_stride;
  logic [CNT_W-1:0]  cfg_count;
  logic              go, running, load, step, last_word;
  logic [RAM_AW-1:0] widx;

  bf_csr #(.DW(DW), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we),
    .s_adr(s_adr), .s_dat_i(s_dat_i), .s_dat_o(s_dat_o), .s_ack(s_ack),
    .running(running), .cfg_src(cfg_src), .cfg_stride(cfg_stride),
    .cfg_count(cfg_count), .go(go)
  );

  bf_addr #(.AW(AW), .ROWS(ROWS), .WPR(WPR)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .src(AW'(cfg_src)), .stride(AW'(cfg_stride)),
    .adr(m_adr), .widx(widx), .last_word(last_word)
  );

  bf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg_count(cfg_count),
    .m_ack(m_ack), .last_word(last_word), .xf_busy(xf_busy),
    .m_cyc(m_cyc), .m_stb(m_stb), .load(load), .step(step),
    .xf_start(xf_start), .running(running)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      ram_waddr <= '0;
    end else begin
      ram_we <= step;
      if (step) begin
        ram_wdata <= m_dat_i;
        ram_waddr <= widx;
      end
    end
  end

  // R5: every RAM write is caused by an accepted read one cycle earlier
  a_r5_write_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(m_cyc && m_stb && m_ack));
  // R4: address holds while a read waits
  a_r4_adr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cyc && !m_ack) |=> (m_cyc && $stable(m_adr)));
endmodule

// File: tb/sim_blkfetch_dma.sv
`timescale 1ns/1ps
module sim_blkfetch_dma;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_cyc, s_stb, s_we;
  logic [1:0]  s_adr;
  logic [31:0] s_dat_i, s_dat_o;
  logic        s_ack;
  logic        m_cyc, m_stb, m_ack;
  logic [31:0] m_adr, m_dat_i;
  logic [31:0] ram_wdata;
  logic [3:0]  ram_waddr;
  logic        ram_we, xf_start, xf_busy;

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_adr_q[$];
  logic [31:0] exp_dat_q[$];
  logic [3:0]  exp_slot_q[$];
  int acks_in_tile = 0;
  int words_total  = 0;
  int starts_seen  = 0;
  int busy_cnt     = 0;
  int busy_len     = 20;
  int wait_cnt     = 0;
  bit prev_start   = 0;
  bit bus_watch    = 0;

  always #10 clk = ~clk;

  blkfetch_dma u0 (
    .clk(clk), .rst_n(rst_n), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we),
    .s_adr(s_adr), .s_dat_i(s_dat_i), .s_dat_o(s_dat_o), .s_ack(s_ack),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_adr(m_adr), .m_dat_i(m_dat_i),
    .m_ack(m_ack), .ram_wdata(ram_wdata), .ram_waddr(ram_waddr),
    .ram_we(ram_we), .xf_start(xf_start), .xf_busy(xf_busy)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h13579BDF;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory slave, engine model and per-cycle comparison against the queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_we) begin
        if (exp_dat_q.size() == 0) check(0, "R5", "unexpected ram_we", 32'(ram_waddr), 0);
        else begin
          logic [31:0] ed; logic [3:0] es;
          ed = exp_dat_q.pop_front(); es = exp_slot_q.pop_front();
          check(ram_wdata == ed, "R5", "ram_wdata", ram_wdata, ed);
          check(ram_waddr == es, "R5", "ram_waddr", 32'(ram_waddr), 32'(es));
        end
      end
      if (m_stb != m_cyc) check(0, "R6", "stb differs from cyc", 32'(m_stb), 32'(m_cyc));
      if (acks_in_tile == 16) begin
        check(!m_cyc, "R6", "cyc after 16th ack", 32'(m_cyc), 0);
        acks_in_tile = 0;
      end
      if (bus_watch && m_cyc) check(0, "R9", "bus read after run end", m_adr, 0);
      if (xf_start) begin
        starts_seen++;
        check(!prev_start, "R7", "start wider than one cycle", 1, 0);
        check(busy_cnt == 0, "R7", "start while busy", 32'(busy_cnt), 0);
        check(words_total == 16 * starts_seen, "R7", "words before start",
              32'(words_total), 32'(16 * starts_seen));
        busy_cnt = busy_len;
      end else if (busy_cnt > 0) busy_cnt--;
      prev_start = xf_start;
      xf_busy = (busy_cnt > 0);
      if (m_ack) m_ack = 1'b0;
      else if (m_cyc && m_stb) begin
        if (wait_cnt > 0) wait_cnt--;
        else begin
          if (exp_adr_q.size() == 0) check(0, "R4", "unexpected read", m_adr, 0);
          else begin
            logic [31:0] ea;
            ea = exp_adr_q.pop_front();
            check(m_adr == ea, "R4", "m_adr", m_adr, ea);
          end
          m_ack   = 1'b1;
          m_dat_i = mem_word(m_adr);
          exp_dat_q.push_back(mem_word(m_adr));
          exp_slot_q.push_back(4'(words_total % 16));
          words_total++;
          acks_in_tile++;
          wait_cnt = $urandom_range(0, 2);
        end
      end
    end
  end

  task automatic csr_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    s_cyc = 1; s_stb = 1; s_we = 1; s_adr = a; s_dat_i = d;
    @(negedge clk);
    check(s_ack, "R2", "write ack", 32'(s_ack), 1);
    s_cyc = 0; s_stb = 0; s_we = 0;
    @(negedge clk);
    check(!s_ack, "R2", "ack single cycle", 32'(s_ack), 0);
  endtask

  task automatic csr_rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    s_cyc = 1; s_stb = 1; s_we = 0; s_adr = a;
    @(negedge clk);
    check(s_ack, "R2", "read ack", 32'(s_ack), 1);
    d = s_dat_o;
    s_cyc = 0; s_stb = 0;
  endtask

  task automatic load_model(logic [31:0] src, logic [31:0] stride, int n);
    for (int k = 0; k < n; k++)
      for (int r = 0; r < 8; r++)
        for (int w = 0; w < 2; w++)
          exp_adr_q.push_back(src + 32'(8 * k) + 32'(r) * stride + 32'(4 * w));
  endtask

  task automatic run(logic [31:0] src, logic [31:0] stride, int n, int blen, bit poke);
    logic [31:0] st;
    int start_base, guard;
    busy_len = blen;
    start_base = starts_seen;
    words_total = 16 * starts_seen;
    load_model(src, stride, n);
    csr_wr(2'd0, src);
    csr_wr(2'd1, stride);
    csr_wr(2'd2, 32'(n));
    csr_wr(2'd3, 32'h1);
    csr_rd(2'd3, st);
    check(st == 1, "R3", "status running", st, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      csr_wr(2'd3, 32'h1); // R10: ignored while active
    end
    guard = 0;
    do begin
      csr_rd(2'd3, st);
      guard++;
    end while (st[0] && guard < 4000);
    check(busy_cnt == 0, "R9", "status cleared while busy", 32'(busy_cnt), 0);
    bus_watch = 1;
    repeat (30) @(negedge clk);
    bus_watch = 0;
    check(starts_seen - start_base == n, "R10", "start pulses in run",
          32'(starts_seen - start_base), 32'(n));
    check(exp_adr_q.size() == 0, "R4", "reads left over", 32'(exp_adr_q.size()), 0);
    check(exp_dat_q.size() == 0, "R5", "writes left over", 32'(exp_dat_q.size()), 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; s_cyc = 0; s_stb = 0; s_we = 0; s_adr = 0; s_dat_i = 0;
    m_ack = 0; m_dat_i = 0; xf_busy = 0;
    repeat (3) @(negedge clk);
    check(!m_cyc && !m_stb, "R1", "bus idle in reset", 32'(m_cyc), 0);
    check(!xf_start && !ram_we, "R1", "strobes low in reset", 32'(xf_start), 0);
    rst_n = 1;
    @(negedge clk);
    csr_rd(2'd3, d);
    check(d == 0, "R1", "status after reset", d, 0);

    csr_wr(2'd0, 32'hDEAD_BEE8);
    csr_wr(2'd1, 32'h0000_0140);
    csr_wr(2'd2, 32'hFFFF_0005);
    csr_rd(2'd0, d); check(d == 32'hDEAD_BEE8, "R2", "src readback", d, 32'hDEAD_BEE8);
    csr_rd(2'd1, d); check(d == 32'h0000_0140, "R2", "stride readback", d, 32'h140);
    csr_rd(2'd2, d); check(d == 32'h0000_0005, "R2", "count readback", d, 5);

    // R3: zero count does not start
    csr_wr(2'd2, 32'h0);
    bus_watch = 1;
    csr_wr(2'd3, 32'h1);
    repeat (20) @(negedge clk);
    bus_watch = 0;
    csr_rd(2'd3, d);
    check(d == 0, "R3", "zero count stays idle", d, 0);
    check(starts_seen == 0, "R3", "no start on zero count", 32'(starts_seen), 0);

    run(32'h0000_1000, 32'd64,  3, 25,  1);  // short busy, R8 gaps
    run(32'h0004_2008, 32'd320, 2, 160, 0);  // long busy: fetch overlaps transform
    run(32'h0000_0100, 32'd8,   1, 5,   0);  // single tile

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule